// File: doc/BRIEF.md
# Sleep Timer Retention and Wakeup

This block keeps a fine-counter value for a radio link-layer core while that core is in deep sleep. When the core enters sleep, the block captures the core's fine counter into an always-on register. When the core wakes, the block returns that value to the core as a one-cycle restore pulse. Software can read and change the kept value through a small register port, but only while the core sleeps. Writes made while the core is awake are dropped.

A two-bit readback selector in the control register chooses what a read of the data register returns. It can return the kept value or one of three views of diagnostic sleep counters. The selector has no effect on writes. A wakeup request bit, raised while the core sleeps, produces a wakeup interrupt after a counted number of low-power clock ticks. The interrupt stays high until the core reports its wakeup sequence. The low-power clock arrives as a single-cycle enable pulse in the system clock domain.

Top module: `stk_top`

## Requirements
- R1: After reset the data register (address 0) reads 0, the control register (address 1) reads 0, `wake_irq_o` is 0 and `restore_vld_o` is 0.
- R2: A one-cycle `sleep_entry_i` pulse copies `fine_cnt_i` into the kept value, and the core counts as asleep from then on. With selector 0, the next cycle's read of address 0 returns the captured value in bits 9:0.
- R3: A `core_wake_i` pulse while asleep causes `restore_vld_o` to be high for exactly the next cycle, with `restore_cnt_o` equal to the kept value. The core then counts as awake.
- R4: A write to address 0 while the core is asleep replaces the kept value with `reg_wdata_i[9:0]`. A write made while the core is awake leaves the kept value unchanged.
- R5: After a write to address 0, a read in the very next cycle still returns the old value. A read one cycle later returns the new value.
- R6: Control bits 6:5 select the address 0 readback. 0 gives the kept value, 1 gives `dsl_dur_i[9:0]`, 2 gives `dsl_time_i[9:0]`, and 3 gives `{dsl_stat_i, dsl_time_i[18:10]}`. Bits 15:10 read 0.
- R7: A write to address 0 updates the kept value in the same way for every selector setting.
- R8: Control bit 0 is the wakeup request. Once the request is high while the core is asleep, `wake_irq_o` rises on the 3rd low-power tick (`lp_tick_i`) after arming, and not before.
- R9: Control bit 2 reads the current level of `wake_irq_o`. The interrupt stays high, even after the request is cleared, until a `core_wake_i` pulse, which clears it in the next cycle.
- R10: A wakeup request while the core is awake never raises `wake_irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lp_tick_i | input | 1 | One-cycle pulse per low-power clock period |
| reg_addr_i | input | 1 | Register select: 0 data, 1 control |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| sleep_entry_i | input | 1 | Core sleep-entry sequence pulse |
| fine_cnt_i | input | 10 | Core fine counter |
| core_wake_i | input | 1 | Core wakeup sequence pulse |
| restore_vld_o | output | 1 | Restore strobe to the core |
| restore_cnt_o | output | 10 | Value restored to the core |
| dsl_dur_i | input | 10 | Deep-sleep duration counter |
| dsl_time_i | input | 19 | Sampled sleep time |
| dsl_stat_i | input | 1 | Sleep status monitor |
| wake_irq_o | output | 1 | Wakeup interrupt |

## Verification
The bench builds the block with its defaults: a 10-bit counter field, a 19-bit sleep time and a 3-tick wakeup delay. The short delay makes it possible to check the tick before the interrupt and the tick that raises it, with ticks spaced several system cycles apart. The 10-bit field lets the high-time view place the status bit at bit 9, just above the nine upper time bits, and the check verifies that placement exactly.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    RD_KEEP    = 2'd0,
    RD_DUR     = 2'd1,
    RD_TIME_LO = 2'd2,
    RD_TIME_HI = 2'd3
  } rd_sel_e;

  localparam int unsigned REQ_BIT = 0;
  localparam int unsigned IRQ_BIT = 2;
  localparam int unsigned SEL_LSB = 5;
endpackage

// File: rtl/stk_retain.sv
module stk_retain #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_entry_i,
  input  logic [CNT_W-1:0] fine_cnt_i,
  input  logic             core_wake_i,
  input  logic             sw_we_i,
  input  logic [CNT_W-1:0] sw_wdata_i,
  output logic             asleep_o,
  output logic [CNT_W-1:0] keep_o,
  output logic             restore_vld_o
);
  logic             asleep_q, pend_q, rst_vld_q;
  logic [CNT_W-1:0] keep_q, pend_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asleep_q  <= 1'b0;
      pend_q    <= 1'b0;
      pend_d_q  <= '0;
      keep_q    <= '0;
      rst_vld_q <= 1'b0;
    end else begin
      if (sleep_entry_i)    asleep_q <= 1'b1;
      else if (core_wake_i) asleep_q <= 1'b0;
      // writes land one cycle late: models the write-idle-read constraint
      pend_q   <= sw_we_i && asleep_q;
      pend_d_q <= sw_wdata_i;
      if (sleep_entry_i) keep_q <= fine_cnt_i;
      else if (pend_q)   keep_q <= pend_d_q;
      rst_vld_q <= core_wake_i && asleep_q;
    end
  end

  assign asleep_o      = asleep_q;
  assign keep_o        = keep_q;
  assign restore_vld_o = rst_vld_q;

  // R2
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_entry_i |=> keep_q == $past(fine_cnt_i));
  // R4
  awake_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!asleep_q && !sleep_entry_i && !pend_q) |=> $stable(keep_q));
  // R3
  restore_awake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_vld_q |-> !asleep_q);
endmodule

// File: rtl/stk_wake_dly.sv
module stk_wake_dly #(
  parameter int unsigned WAKE_TICKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lp_tick_i,
  input  logic req_i,
  input  logic asleep_i,
  input  logic core_wake_i,
  output logic irq_o
);
  localparam int unsigned TICK_W = $clog2(WAKE_TICKS + 1);
  localparam logic [TICK_W-1:0] LAST = TICK_W'(WAKE_TICKS - 1);

  logic              armed_q, irq_q;
  logic [TICK_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (core_wake_i || !asleep_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      if (core_wake_i) irq_q <= 1'b0;
    end else if (armed_q) begin
      if (lp_tick_i) begin
        if (cnt_q == LAST) begin
          irq_q   <= 1'b1;
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end else if (req_i && !irq_q) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end
  end

  assign irq_o = irq_q;

  // R8
  irq_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(lp_tick_i) && $past(asleep_i));
  // R9
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !core_wake_i) |=> irq_q);
  // R9
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_wake_i |=> !irq_q);
endmodule

// File: rtl/stk_read_mux.sv
module stk_read_mux
  import stk_pkg::*;
#(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned DW     = 16,
  parameter int unsigned TIME_W = 2 * CNT_W - 1
) (
  input  logic              addr_i,
  input  rd_sel_e           sel_i,
  input  logic [CNT_W-1:0]  keep_i,
  input  logic [CNT_W-1:0]  dur_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              stat_i,
  input  logic              req_i,
  input  logic              irq_i,
  output logic [DW-1:0]     rdata_o
);
  logic [CNT_W-1:0] field;
  logic [DW-1:0]    ctrl;

  always_comb begin
    unique case (sel_i)
      RD_KEEP:    field = keep_i;
      RD_DUR:     field = dur_i;
      RD_TIME_LO: field = time_i[CNT_W-1:0];
      default:    field = {stat_i, time_i[TIME_W-1:CNT_W]};
    endcase
    ctrl = '0;
    ctrl[SEL_LSB +: 2] = sel_i;
    ctrl[IRQ_BIT]      = irq_i;
    ctrl[REQ_BIT]      = req_i;
    rdata_o = addr_i ? ctrl : {{(DW-CNT_W){1'b0}}, field};
  end
endmodule

// File: rtl/stk_top.sv
module stk_top
  import stk_pkg::*;
#(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned DW         = 16,
  parameter int unsigned WAKE_TICKS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 lp_tick_i,
  input  logic                 reg_addr_i,
  input  logic                 reg_we_i,
  input  logic [DW-1:0]        reg_wdata_i,
  output logic [DW-1:0]        reg_rdata_o,
  input  logic                 sleep_entry_i,
  input  logic [CNT_W-1:0]     fine_cnt_i,
  input  logic                 core_wake_i,
  output logic                 restore_vld_o,
  output logic [CNT_W-1:0]     restore_cnt_o,
  input  logic [CNT_W-1:0]     dsl_dur_i,
  input  logic [2*CNT_W-2:0]   dsl_time_i,
  input  logic                 dsl_stat_i,
  output logic                 wake_irq_o
);
  localparam int unsigned TIME_W = 2 * CNT_W - 1;

  logic             req_q, asleep, irq;
  rd_sel_e          sel_q;
  logic [CNT_W-1:0] keep;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      sel_q <= RD_KEEP;
    end else if (reg_we_i && reg_addr_i) begin
      req_q <= reg_wdata_i[REQ_BIT];
      sel_q <= rd_sel_e'(reg_wdata_i[SEL_LSB +: 2]);
    end
  end

  stk_retain #(.CNT_W(CNT_W)) u_retain (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sleep_entry_i (sleep_entry_i),
    .fine_cnt_i    (fine_cnt_i),
    .core_wake_i   (core_wake_i),
    .sw_we_i       (reg_we_i && !reg_addr_i),
    .sw_wdata_i    (reg_wdata_i[CNT_W-1:0]),
    .asleep_o      (asleep),
    .keep_o        (keep),
    .restore_vld_o (restore_vld_o)
  );

  stk_wake_dly #(.WAKE_TICKS(WAKE_TICKS)) u_wake (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lp_tick_i   (lp_tick_i),
    .req_i       (req_q),
    .asleep_i    (asleep),
    .core_wake_i (core_wake_i),
    .irq_o       (irq)
  );

  stk_read_mux #(.CNT_W(CNT_W), .DW(DW), .TIME_W(TIME_W)) u_rd (
    .addr_i  (reg_addr_i),
    .sel_i   (sel_q),
    .keep_i  (keep),
    .dur_i   (dsl_dur_i),
    .time_i  (dsl_time_i),
    .stat_i  (dsl_stat_i),
    .req_i   (req_q),
    .irq_i   (irq),
    .rdata_o (reg_rdata_o)
  );

  assign restore_cnt_o = keep;
  assign wake_irq_o    = irq;

  // R10
  no_awake_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !asleep |=> !$rose(irq));
  // R3
  restore_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_vld_o |=> !restore_vld_o);
endmodule

// File: tb/stk_top_bench.sv
module stk_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lp_tick = 1'b0, addr = 1'b0, we = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic        sleep_entry = 1'b0, core_wake = 1'b0, dsl_stat = 1'b1;
  logic [9:0]  fine_cnt = '0, dsl_dur = 10'h3C1, restore_cnt;
  logic [18:0] dsl_time = 19'h4ABCD;
  logic        restore_vld, irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  stk_top u_stk_top (
    .clk_i(clk), .rst_ni(rst_n), .lp_tick_i(lp_tick), .reg_addr_i(addr),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sleep_entry_i(sleep_entry), .fine_cnt_i(fine_cnt), .core_wake_i(core_wake),
    .restore_vld_o(restore_vld), .restore_cnt_o(restore_cnt),
    .dsl_dur_i(dsl_dur), .dsl_time_i(dsl_time), .dsl_stat_i(dsl_stat),
    .wake_irq_o(irq)
  );

  // {sel, expected address 0 readback}
  localparam logic [11:0] VEC [4] = '{
    {2'd1, 10'h3C1}, {2'd2, 10'h3CD}, {2'd3, 10'h32A}, {2'd0, 10'h155}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic tick();
    lp_tick = 1'b1; @(negedge clk); lp_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_sleep(input logic [9:0] v);
    fine_cnt = v; sleep_entry = 1'b1; @(negedge clk); sleep_entry = 1'b0;
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rd(0, d); chk("R1 data", d, 16'h0);
    rd(1, d); chk("R1 ctrl", d, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 restore", {15'b0, restore_vld}, 16'h0);
    rst_n = 1'b1; @(negedge clk);

    pulse_sleep(10'h2A5);
    rd(0, d); chk("R2 capture", d, 16'h02A5);

    wr(0, 16'hF155);
    rd(0, d); chk("R5 old value", d, 16'h02A5);
    @(negedge clk);
    rd(0, d); chk("R4 R5 new value", d, 16'h0155);

    for (int i = 0; i < 4; i++) begin
      wr(1, {9'b0, VEC[i][11:10], 5'b0});
      rd(1, d); chk("R6 sel readback", d, {9'b0, VEC[i][11:10], 5'b0});
      rd(0, d); chk("R6 mux", d, {6'b0, VEC[i][9:0]});
    end

    wr(1, 16'h0040);
    wr(0, 16'h00F0);
    @(negedge clk);
    rd(0, d); chk("R7 sel2 still time", d, 16'h03CD);
    wr(1, 16'h0000);
    rd(0, d); chk("R7 write under sel2", d, 16'h00F0);

    wr(1, 16'h0001);
    @(negedge clk);
    tick(); tick();
    chk("R8 no irq after 2", {15'b0, irq}, 16'h0);
    tick();
    chk("R8 irq after 3", {15'b0, irq}, 16'h1);
    rd(1, d); chk("R9 ctrl irq bit", d, 16'h0005);
    wr(1, 16'h0000);
    tick();
    chk("R9 irq holds", {15'b0, irq}, 16'h1);

    core_wake = 1'b1; @(negedge clk); core_wake = 1'b0;
    chk("R3 restore vld", {15'b0, restore_vld}, 16'h1);
    chk("R3 restore cnt", {6'b0, restore_cnt}, 16'h00F0);
    chk("R9 irq cleared", {15'b0, irq}, 16'h0);
    @(negedge clk);
    chk("R3 single pulse", {15'b0, restore_vld}, 16'h0);

    wr(0, 16'h03FF);
    repeat (2) @(negedge clk);
    rd(0, d); chk("R4 awake write dropped", d, 16'h00F0);

    wr(1, 16'h0001);
    repeat (5) tick();
    chk("R10 no irq awake", {15'b0, irq}, 16'h0);
    wr(1, 16'h0000);

    pulse_sleep(10'h011);
    rd(0, d); chk("R2 second capture", d, 16'h0011);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule